// File: doc/BRIEF.md
# One-Hot Instruction Fetch and Decode Unit

This block reads 64-bit instruction words from an instruction memory that has its own address space, separate from data memory. It turns each word into a binary-coded instruction record for an execution stage. In each word the register operands and the operation are written as one-hot vectors. The unit converts every one-hot field into a small binary index. An all-zero second-source field is reported as a selection of the prophet stack pointer. If the immediate flag is set, the unit fetches the following word as the immediate operand and then steps the program counter by two instead of one. A redirect port loads a new fetch address for jumps, calls and returns. The unit also holds the prophet stack pointer register at its reset value.

The sequencer runs through four named states:
- `ST_ISSUE` sends a read of the program counter address and always moves to `ST_OPWORD`.
- `ST_OPWORD` captures the returned word. If the immediate flag is set, it reads pc+1 and moves to `ST_IMMWORD`. Otherwise it moves to `ST_PRESENT`.
- `ST_IMMWORD` captures the immediate and moves to `ST_PRESENT`.
- `ST_PRESENT` shows the decoded record until the consumer accepts it. It then advances the pc and returns to `ST_ISSUE`.

A redirect from any state forces the next state to `ST_ISSUE` with the new pc. The memory read port has a fixed latency of one cycle: data for a read issued in cycle t is on `imem_rdata` in cycle t+1.

Top module: `fetch_decode_unit`

## Requirements
- R1: During and after reset `dec_valid` is 0. In the first cycle after reset without a redirect, the unit reads address 0. `psp_value` reads 0xFFFFFFFE00000000.
- R2: Word layout, most significant bit first:
  - bit 63 is ignored;
  - bit 62 is the immediate flag;
  - bits 61:53 select source 0;
  - bits 52:44 select source 1;
  - bits 43:35 select the destination;
  - bits 34:14 select the operation;
  - bits 13:0 are padding.
- R3: Each 9-bit register field maps bit i to index i (0 to 8) on its 4-bit output. With several bits set, the lowest set bit is reported. A zero source-0 or destination field gives index 0 with its `_none` flag set to 1.
- R4: A source-1 field of all zeros gives `dec_src1_psp`=1 and `dec_src1_idx`=0. Any nonzero source-1 field gives `dec_src1_psp`=0.
- R5: The 21-bit operation field maps bit i to `dec_op_idx`=i. With several bits set, the lowest set bit is reported. A zero field gives 0.
- R6: If the immediate flag is 1, `dec_has_imm`=1 and `dec_imm` equals the word at pc+1. If the flag is 0, `dec_has_imm`=0 and `dec_imm`=0.
- R7: When a record is accepted (`dec_valid` and `dec_ready` both 1) with no redirect, the next record's pc is the old pc plus 1, or plus 2 if the record carried an immediate. The pc wraps modulo 2^PC_W.
- R8: `dec_illegal` is 1 exactly when any of these holds:
  - any register field has more than one bit set;
  - the operation field does not have exactly one bit set;
  - the padding is nonzero.
- R9: While `dec_valid` is 1 and `dec_ready` is 0, the record and its pc stay unchanged in the next cycle.
- R10: A redirect overrides the sequential step. The next fetch is from `redir_target`. An immediate read that is in flight is dropped, and the next record is the one at the target.
- R11: In a cycle with `redir_valid` high, `dec_valid` is 0 even if `dec_ready` is 1. The instruction on show is not consumed.
- R12: `psp_value` keeps its reset value while the unit runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_en | output | 1 | Instruction memory read strobe |
| imem_addr | output | PC_W | Instruction memory word address |
| imem_rdata | input | 64 | Read data, one cycle after the strobe |
| redir_valid | input | 1 | Load a new fetch address |
| redir_target | input | PC_W | New fetch address |
| dec_valid | output | 1 | Decoded record available |
| dec_ready | input | 1 | Consumer accepts the record |
| dec_pc | output | PC_W | Address of the decoded instruction |
| dec_src0_idx | output | 4 | Source-0 register index |
| dec_src0_none | output | 1 | Source-0 field was all zero |
| dec_src1_idx | output | 4 | Source-1 register index |
| dec_src1_psp | output | 1 | Source 1 is the prophet stack pointer |
| dec_dst_idx | output | 4 | Destination register index |
| dec_dst_none | output | 1 | Destination field was all zero |
| dec_op_idx | output | 5 | Operation index |
| dec_has_imm | output | 1 | Record carries an immediate |
| dec_imm | output | 64 | Immediate value, 0 when absent |
| dec_illegal | output | 1 | Malformed encoding |
| psp_value | output | 64 | Prophet stack pointer register |

## Verification
A redirect and a sequential advance can fall in the same cycle. This happens when the consumer is ready for a shown record and the redirect arrives at the same time. It also happens when the redirect arrives just as the immediate word is being requested.

The bench provokes the first case by waiting until a record is on show with `dec_ready` high, then raising `redir_valid`. It judges the result in two steps. `dec_valid` must drop in that cycle. The next accepted record must carry the target pc, not the old pc plus one or two.

For the second case, the bench watches for a read at the shown pc plus 1 and redirects in that cycle. The record that follows must come from the target, and its immediate must be the word after the target.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int WORD_W    = 64;
    localparam int REG_N     = 9;
    localparam int OPC_N     = 21;
    localparam int PAD_W     = 14;
    localparam int REG_IDX_W = $clog2(REG_N);
    localparam int OPC_IDX_W = $clog2(OPC_N);

    localparam int IMM_BIT = 62;
    localparam int OP0_LSB = 53;
    localparam int OP1_LSB = 44;
    localparam int DST_LSB = 35;
    localparam int OPC_LSB = 14;

    typedef enum logic [1:0] {
        ST_ISSUE,
        ST_OPWORD,
        ST_IMMWORD,
        ST_PRESENT
    } fetch_state_t;

    typedef struct packed {
        logic [REG_IDX_W-1:0] src0_idx;
        logic                 src0_none;
        logic [REG_IDX_W-1:0] src1_idx;
        logic                 src1_psp;
        logic [REG_IDX_W-1:0] dst_idx;
        logic                 dst_none;
        logic [OPC_IDX_W-1:0] op_idx;
        logic                 has_imm;
        logic                 illegal;
    } dec_fields_t;
endpackage

// File: rtl/oh_index.sv
module oh_index #(
    parameter int N  = 9,
    parameter int IW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          zero,
    output logic          multi
);
    // lowest set bit wins: scan from the top down
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign zero  = ~|vec;
    assign multi = |(vec & (vec - N'(1)));

    // R3: a clean one-hot vector must point at its own set bit
    always_comb begin
        if (!$isunknown(vec) && !zero && !multi) begin
            a_r3_index_hits_bit: assert (vec[idx] && $countones(vec) == 1);
        end
    end
endmodule

// File: rtl/insn_decode.sv
module insn_decode
    import fetch_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output dec_fields_t       fields
);
    logic [REG_IDX_W-1:0] ridx  [3];
    logic                 rzero [3];
    logic                 rmulti[3];
    logic [OPC_IDX_W-1:0] oidx;
    logic                 ozero;
    logic                 omulti;
    logic [OPC_N-1:0]     opc;
    logic [PAD_W-1:0]     pad;
    logic                 unused_top_bit;

    assign opc            = word[OPC_LSB +: OPC_N];
    assign pad            = word[PAD_W-1:0];
    assign unused_top_bit = word[WORD_W-1];

    // three register fields share one converter shape
    for (genvar g = 0; g < 3; g++) begin : g_reg
        localparam int LSB = (g == 0) ? OP0_LSB : (g == 1) ? OP1_LSB : DST_LSB;
        oh_index #(.N(REG_N), .IW(REG_IDX_W)) u_reg (
            .vec  (word[LSB +: REG_N]),
            .idx  (ridx[g]),
            .zero (rzero[g]),
            .multi(rmulti[g])
        );
    end

    oh_index #(.N(OPC_N), .IW(OPC_IDX_W)) u_opc (
        .vec  (opc),
        .idx  (oidx),
        .zero (ozero),
        .multi(omulti)
    );

    always_comb begin
        fields.src0_idx  = ridx[0];
        fields.src0_none = rzero[0];
        fields.src1_idx  = ridx[1];
        fields.src1_psp  = rzero[1];
        fields.dst_idx   = ridx[2];
        fields.dst_none  = rzero[2];
        fields.op_idx    = oidx;
        fields.has_imm   = word[IMM_BIT];
        fields.illegal   = rmulti[0] | rmulti[1] | rmulti[2]
                         | omulti | ozero | (|pad);
    end

    // R8: an operation field that is not exactly one-hot is always flagged
    always_comb begin
        if (!$isunknown(word) && $countones(opc) != 1) begin
            a_r8_bad_opcode_flagged: assert (fields.illegal);
        end
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import fetch_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              redir_valid,
    input  logic [PC_W-1:0]   redir_target,
    output logic              imem_en,
    output logic [PC_W-1:0]   imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PC_W-1:0]   out_pc,
    output logic [WORD_W-1:0] out_word,
    output logic [WORD_W-1:0] out_imm
);
    localparam logic [PC_W-1:0] STEP1 = PC_W'(1);
    localparam logic [PC_W-1:0] STEP2 = PC_W'(2);

    fetch_state_t      state_q, state_d;
    logic [PC_W-1:0]   pc_q;
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] imm_q;
    logic              take;

    assign take = (state_q == ST_PRESENT) && out_ready && !redir_valid;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ISSUE:   state_d = ST_OPWORD;
            ST_OPWORD:  state_d = imem_rdata[IMM_BIT] ? ST_IMMWORD : ST_PRESENT;
            ST_IMMWORD: state_d = ST_PRESENT;
            ST_PRESENT: if (out_ready) state_d = ST_ISSUE;
            default:    state_d = ST_ISSUE;
        endcase
        if (redir_valid) state_d = ST_ISSUE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_ISSUE;
        else     state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            word_q <= '0;
            imm_q  <= '0;
        end else if (redir_valid) begin
            pc_q <= redir_target;
        end else begin
            if (take) pc_q <= pc_q + (word_q[IMM_BIT] ? STEP2 : STEP1);
            if (state_q == ST_OPWORD) begin
                word_q <= imem_rdata;
                imm_q  <= '0;
            end
            if (state_q == ST_IMMWORD) imm_q <= imem_rdata;
        end
    end

    // output process
    always_comb begin
        imem_en   = 1'b0;
        imem_addr = pc_q;
        out_valid = 1'b0;
        unique case (state_q)
            ST_ISSUE:   imem_en = !redir_valid;
            ST_OPWORD: begin
                imem_en   = !redir_valid && imem_rdata[IMM_BIT];
                imem_addr = pc_q + STEP1;
            end
            ST_IMMWORD: imem_en = 1'b0;
            ST_PRESENT: out_valid = !redir_valid;
            default:    imem_en = 1'b0;
        endcase
    end

    assign out_pc   = pc_q;
    assign out_word = word_q;
    assign out_imm  = imm_q;

    a_r1_first_fetch_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !redir_valid) |-> (imem_en && imem_addr == '0));

    a_r10_redirect_fetches_target: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (redir_valid || (imem_en && imem_addr == $past(redir_target))));

    a_r7_pc_step: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=>
            (pc_q == $past(pc_q) + ($past(word_q[IMM_BIT]) ? STEP2 : STEP1)));

    a_r6_no_stale_imm: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PRESENT && !word_q[IMM_BIT]) |-> (imm_q == '0));
endmodule

// File: rtl/fetch_decode_unit.sv
module fetch_decode_unit
    import fetch_pkg::*;
#(
    parameter int          PC_W     = 16,
    parameter logic [63:0] PSP_INIT = 64'hFFFF_FFFE_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 imem_en,
    output logic [PC_W-1:0]      imem_addr,
    input  logic [63:0]          imem_rdata,
    input  logic                 redir_valid,
    input  logic [PC_W-1:0]      redir_target,
    output logic                 dec_valid,
    input  logic                 dec_ready,
    output logic [PC_W-1:0]      dec_pc,
    output logic [3:0]           dec_src0_idx,
    output logic                 dec_src0_none,
    output logic [3:0]           dec_src1_idx,
    output logic                 dec_src1_psp,
    output logic [3:0]           dec_dst_idx,
    output logic                 dec_dst_none,
    output logic [4:0]           dec_op_idx,
    output logic                 dec_has_imm,
    output logic [63:0]          dec_imm,
    output logic                 dec_illegal,
    output logic [63:0]          psp_value
);
    logic [WORD_W-1:0] word;
    dec_fields_t       fields;
    logic [63:0]       psp_q;

    fetch_seq #(.PC_W(PC_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .redir_valid (redir_valid),
        .redir_target(redir_target),
        .imem_en     (imem_en),
        .imem_addr   (imem_addr),
        .imem_rdata  (imem_rdata),
        .out_valid   (dec_valid),
        .out_ready   (dec_ready),
        .out_pc      (dec_pc),
        .out_word    (word),
        .out_imm     (dec_imm)
    );

    insn_decode u_dec (
        .word  (word),
        .fields(fields)
    );

    assign dec_src0_idx  = fields.src0_idx;
    assign dec_src0_none = fields.src0_none;
    assign dec_src1_idx  = fields.src1_idx;
    assign dec_src1_psp  = fields.src1_psp;
    assign dec_dst_idx   = fields.dst_idx;
    assign dec_dst_none  = fields.dst_none;
    assign dec_op_idx    = fields.op_idx;
    assign dec_has_imm   = fields.has_imm;
    assign dec_illegal   = fields.illegal;

    // prophet stack pointer: held at its start address
    always_ff @(posedge clk) begin
        if (rst) psp_q <= PSP_INIT;
        else     psp_q <= psp_q;
    end
    assign psp_value = psp_q;

    a_r9_hold_record: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_ready) |=>
            ($stable(dec_pc) && $stable(dec_imm) && $stable(dec_op_idx)
             && $stable(dec_illegal)));

    a_r4_psp_select: assert property (@(posedge clk) disable iff (rst)
        dec_src1_psp |-> (dec_src1_idx == '0));
endmodule

// File: tb/fetch_decode_unit_test.sv
`timescale 1ns/100ps
module fetch_decode_unit_test;
    localparam int PC_W = 16;
    localparam logic [63:0] PSP_EXP = 64'hFFFF_FFFE_0000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic imem_en;
    logic [PC_W-1:0] imem_addr;
    logic [63:0] imem_rdata = '0;
    logic redir_valid = 1'b0;
    logic [PC_W-1:0] redir_target = '0;
    logic dec_valid;
    logic dec_ready = 1'b0;
    logic [PC_W-1:0] dec_pc;
    logic [3:0] dec_src0_idx, dec_src1_idx, dec_dst_idx;
    logic dec_src0_none, dec_src1_psp, dec_dst_none;
    logic [4:0] dec_op_idx;
    logic dec_has_imm, dec_illegal;
    logic [63:0] dec_imm, psp_value;

    always #2.5 clk = ~clk;

    fetch_decode_unit #(.PC_W(PC_W)) uut (
        .clk(clk), .rst(rst), .imem_en(imem_en), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .redir_valid(redir_valid),
        .redir_target(redir_target), .dec_valid(dec_valid),
        .dec_ready(dec_ready), .dec_pc(dec_pc),
        .dec_src0_idx(dec_src0_idx), .dec_src0_none(dec_src0_none),
        .dec_src1_idx(dec_src1_idx), .dec_src1_psp(dec_src1_psp),
        .dec_dst_idx(dec_dst_idx), .dec_dst_none(dec_dst_none),
        .dec_op_idx(dec_op_idx), .dec_has_imm(dec_has_imm),
        .dec_imm(dec_imm), .dec_illegal(dec_illegal), .psp_value(psp_value)
    );

    logic [63:0] mem [0:127];
    int n_cmp = 0;
    int n_bad = 0;
    int accepted = 0;
    int cyc = 0;
    int ready_mode = 0;
    bit run = 1'b0;
    logic [PC_W-1:0] exp_pc = '0;
    bit pend_valid = 1'b0;
    logic [PC_W-1:0] pend_tgt = '0;
    string pend_tag = "";
    bit hold_pend = 1'b0;
    logic [PC_W-1:0] hold_pc = '0;
    logic [63:0] hold_imm = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] make_word(input int k);
        logic [63:0] w;
        logic [8:0] op0, op1, dst;
        logic [20:0] opc;
        logic [13:0] pad;
        op0 = 9'(1) << (k % 9);
        op1 = (k % 10 == 9) ? 9'd0 : (9'(1) << (k % 10));
        dst = (k % 7 == 6) ? 9'd0 : (9'(1) << ((k * 4) % 9));
        opc = 21'(1) << (k % 21);
        pad = '0;
        if (k % 11 == 5) opc = opc | (21'(1) << ((k + 3) % 21));
        if (k % 13 == 7) pad = 14'(k);
        if (k % 17 == 3) opc = '0;
        if (k % 19 == 4) dst = dst | 9'h100;
        w = {(k % 4 == 1), (k % 3 == 0), op0, op1, dst, opc, pad};
        return w;
    endfunction

    function automatic int low_idx(input logic [20:0] v);
        for (int i = 0; i < 21; i++) if (v[i]) return i;
        return 0;
    endfunction

    // memory: one-cycle read latency
    always @(posedge clk) if (imem_en) imem_rdata <= mem[imem_addr[6:0]];

    // consumer ready pattern
    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst)                  dec_ready = 1'b0;
        else if (ready_mode == 0) dec_ready = 1'b1;
        else                      dec_ready = (cyc % 3) != 2;
    end

    // record checker
    always @(negedge clk) begin
        if (run) begin
            if (redir_valid) chk("R11 valid during redirect", 64'(dec_valid), 64'd0);
            if (hold_pend && dec_valid) begin
                chk("R9 held pc", 64'(dec_pc), 64'(hold_pc));
                chk("R9 held imm", dec_imm, hold_imm);
            end
            hold_pend = dec_valid && !dec_ready;
            hold_pc = dec_pc;
            hold_imm = dec_imm;
            if (dec_valid && dec_ready) begin
                logic [63:0] w;
                logic [8:0] f0, f1, fd;
                logic [20:0] fo;
                bit ill;
                w  = mem[exp_pc[6:0]];
                f0 = w[61:53]; f1 = w[52:44]; fd = w[43:35]; fo = w[34:14];
                ill = ($countones(f0) > 1) || ($countones(f1) > 1)
                   || ($countones(fd) > 1) || ($countones(fo) != 1) || (w[13:0] != 0);
                if (pend_valid) begin
                    chk(pend_tag, 64'(dec_pc), 64'(pend_tgt));
                    pend_valid = 1'b0;
                end
                chk("R7 pc", 64'(dec_pc), 64'(exp_pc));
                chk("R3 src0", {59'd0, dec_src0_none, dec_src0_idx},
                    {59'd0, f0 == 0, 4'(low_idx(21'(f0)))});
                chk("R4 src1", {59'd0, dec_src1_psp, dec_src1_idx},
                    {59'd0, f1 == 0, 4'(low_idx(21'(f1)))});
                chk("R3 dst", {59'd0, dec_dst_none, dec_dst_idx},
                    {59'd0, fd == 0, 4'(low_idx(21'(fd)))});
                chk("R5 op", 64'(dec_op_idx), 64'(low_idx(fo)));
                chk("R2 imm flag", 64'(dec_has_imm), 64'(w[62]));
                chk("R6 imm", dec_imm, w[62] ? mem[7'(exp_pc + 1)] : 64'd0);
                chk("R8 illegal", 64'(dec_illegal), 64'(ill));
                exp_pc = exp_pc + (w[62] ? PC_W'(2) : PC_W'(1));
                accepted++;
            end
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic redirect(input logic [PC_W-1:0] tgt, input string tag);
        redir_valid = 1'b1;
        redir_target = tgt;
        @(posedge clk); #1;
        redir_valid = 1'b0;
        exp_pc = tgt;
        pend_valid = 1'b1;
        pend_tgt = tgt;
        pend_tag = tag;
    endtask

    task automatic wait_accepts(input int n);
        int goal;
        goal = accepted + n;
        while (accepted < goal) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        report();
    end

    initial begin
        begin
            int addr, k;
            logic [63:0] w;
            addr = 0; k = 0;
            while (addr < 128) begin
                w = make_word(k);
                mem[addr] = w;
                if (w[62] && addr + 1 < 128)
                    mem[addr + 1] = {32'(k) * 32'h9E37_79B9, 32'hA5A5_0000 ^ 32'(k)};
                addr += w[62] ? 2 : 1;
                k++;
            end
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", 64'(dec_valid), 64'd0);
        chk("R1 first fetch", {47'd0, imem_en, imem_addr}, {47'd0, 1'b1, 16'd0});
        chk("R1 psp", psp_value, PSP_EXP);
        @(posedge clk); #1;
        run = 1'b1;
        ready_mode = 1;
        wait_accepts(70);
        // redirect at a random point of the flow, wrapping past the top
        redirect(16'hFFFE, "R10 wrap target");
        wait_accepts(20);
        ready_mode = 0;
        // collision: record on show, consumer ready, redirect the same cycle
        do begin @(posedge clk); #1; end while (!dec_valid);
        redirect(16'd40, "R11 target after collision");
        wait_accepts(10);
        // redirect while the immediate word is being requested
        do begin @(posedge clk); #1; end while (!(imem_en && imem_addr == PC_W'(exp_pc + 1)));
        redirect(16'd77, "R10 target after dropped imm");
        wait_accepts(10);
        ready_mode = 1;
        do begin @(posedge clk); #1; end while (!(imem_en && imem_addr == PC_W'(exp_pc + 1)));
        redirect(16'd3, "R10 second dropped imm");
        wait_accepts(40);
        @(negedge clk);
        chk("R12 psp kept", psp_value, PSP_EXP);
        report();
    end
endmodule